// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a synchronous design read and write a 32K x 8 asynchronous static RAM. The host side has a single-cycle request strobe with a read/write flag, a 15-bit address and write data. A level `ready` output shows when a request can be taken. A one-cycle `ack` pulse marks each finished access. For reads, the data appears on `rdata` in the same cycle as the pulse.

On the memory side the controller drives active-low chip select, write enable and output enable, plus the address. The bidirectional data bus is split into an output, an output enable and an input. Every memory timing value is held in nanoseconds and chosen by an access-time speed bin parameter (45, 55, 70 or 100 ns). Each value becomes a whole number of clock cycles using the clock period parameter. The rule is the ceiling of the time divided by the period, and never fewer than one cycle.

Reads are gated by output enable. Writes are controlled by write enable, with output enable held high. After every read the controller holds the bus idle for a turnaround window before it may drive data again, so the controller and the memory never drive the bus at the same time.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, chip select, write enable and output enable are high, the data drive is off, `ready` is high, `ack` is low and `rdata` is zero.
- R2: While idle, chip select is high and `ready` is high. A request is taken only on a clock edge where `ready` is high. A request strobe seen while busy is dropped, never queued, and never reaches the memory.
- R3: A read holds chip select and output enable low and write enable high for exactly N_RD cycles. N_RD is the ceiling of the largest of address access, output-enable access and read cycle time, divided by the clock period. For the 55 ns bin at 20 ns this is 3.
- R4: Read data is sampled from the memory bus on the clock edge that ends the last access cycle. It appears on `rdata` together with a one-cycle `ack` in the next cycle, and `rdata` keeps that value until the next read completes.
- R5: A write has three phases, with output enable high and data driven in all of them. First comes one setup cycle with write enable high. Then write enable is low for N_WP cycles. Last comes one hold cycle with write enable high again. N_WP is the ceiling of the largest of write pulse, address-to-end-of-write and data setup time, divided by the clock period. For the 55 ns bin at 20 ns this is 3.
- R6: The memory address equals the host address taken with the request for every cycle that chip select is low. The driven data equals the host write data for every cycle that the drive is on.
- R7: After the write hold cycle, the controller returns to idle with `ready` high and `ack` high for that one cycle.
- R8: After a read, chip select and output enable stay high with the drive off and `ready` low for N_TA cycles. N_TA is the ceiling of the bin's output-to-high-Z time divided by the clock period. For the 55 ns bin at 20 ns this is 1. The drive is never on while output enable is low.
- R9: `ack` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Request strobe, taken when `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle and able to take a request |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last data read |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_addr | output | 15 | Memory address |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Enable for `sram_dq_out` onto the shared bus |
| sram_dq_in | input | 8 | Data from the shared bus |

## Verification
The memory model in the bench returns junk until the access count has run. A controller that samples one edge early therefore latches a wrong byte. A read followed straight by a write checks the turnaround window: a design that skips it turns on its drive while the memory may still hold the bus. Request strobes are pulsed during busy cycles to a distinct address, which is read back later. A controller that queued or accepted such a strobe would show a changed byte there, or extra bus cycles. Writes to the lowest and highest addresses, and back-to-back read and write pairs, catch address latching and phase lengths that drift by a cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_TURN  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_PULSE = 3'd4,
    ST_WR_HOLD  = 3'd5
  } seq_state_t;

  // ceiling division with a floor of one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // per-bin timing, nanoseconds; unknown bins fall back to 55
  function automatic int unsigned t_addr_access(input int unsigned bin);
    case (bin)
      45:      return 45;
      70:      return 70;
      100:     return 100;
      default: return 55;
    endcase
  endfunction

  function automatic int unsigned t_oe_access(input int unsigned bin);
    case (bin)
      70:      return 35;
      100:     return 50;
      default: return 25;
    endcase
  endfunction

  function automatic int unsigned t_we_pulse(input int unsigned bin);
    case (bin)
      70:      return 50;
      100:     return 60;
      default: return 40;
    endcase
  endfunction

  function automatic int unsigned t_addr_to_wend(input int unsigned bin);
    case (bin)
      70:      return 60;
      100:     return 80;
      default: return 45;
    endcase
  endfunction

  function automatic int unsigned t_data_setup(input int unsigned bin);
    case (bin)
      70:      return 30;
      100:     return 50;
      default: return 25;
    endcase
  endfunction

  function automatic int unsigned t_bus_release(input int unsigned bin);
    case (bin)
      70:      return 30;
      100:     return 35;
      default: return 20;
    endcase
  endfunction

  function automatic int unsigned read_cycles(input int unsigned bin,
                                              input int unsigned period_ns);
    return ns_to_cycles(max3(t_addr_access(bin), t_oe_access(bin), bin), period_ns);
  endfunction

  function automatic int unsigned write_cycles(input int unsigned bin,
                                               input int unsigned period_ns);
    return ns_to_cycles(max3(t_we_pulse(bin), t_addr_to_wend(bin), t_data_setup(bin)),
                        period_ns);
  endfunction

  function automatic int unsigned turn_cycles(input int unsigned bin,
                                              input int unsigned period_ns);
    return ns_to_cycles(t_bus_release(bin), period_ns);
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // phase lengths rely on a strict one-per-cycle count down
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned WP_CYC = 3,
  parameter int unsigned TA_CYC = 1,
  parameter int unsigned CNT_W  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_write,
  output logic ready,
  output logic accept,
  output logic capture,
  output logic ack,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic drv
);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

  seq_state_t       state_q, state_d;
  logic             tmr_load, tmr_expired, wr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             ce_n_d, we_n_d, oe_n_d, drv_d, ack_d;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  // next-state
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    wr_done  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (req_write) begin
            state_d = ST_WR_SETUP;
          end else begin
            state_d  = ST_RD_ACC;
            tmr_load = 1'b1;
            tmr_val  = RD_LOAD;
          end
        end
      end
      ST_RD_ACC: begin
        if (tmr_expired) begin
          capture  = 1'b1;
          state_d  = ST_RD_TURN;
          tmr_load = 1'b1;
          tmr_val  = TA_LOAD;
        end
      end
      ST_RD_TURN: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = WP_LOAD;
      end
      ST_WR_PULSE: begin
        if (tmr_expired) state_d = ST_WR_HOLD;
      end
      ST_WR_HOLD: begin
        state_d = ST_IDLE;
        wr_done = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pin values decoded from the coming state, so pins leave flops
  always_comb begin
    ce_n_d = 1'b1;
    we_n_d = 1'b1;
    oe_n_d = 1'b1;
    drv_d  = 1'b0;
    unique case (state_d)
      ST_RD_ACC: begin
        ce_n_d = 1'b0;
        oe_n_d = 1'b0;
      end
      ST_WR_SETUP, ST_WR_HOLD: begin
        ce_n_d = 1'b0;
        drv_d  = 1'b1;
      end
      ST_WR_PULSE: begin
        ce_n_d = 1'b0;
        we_n_d = 1'b0;
        drv_d  = 1'b1;
      end
      default: ;
    endcase
    ack_d = capture | wr_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      drv     <= 1'b0;
      ack     <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n    <= ce_n_d;
      we_n    <= we_n_d;
      oe_n    <= oe_n_d;
      drv     <= drv_d;
      ack     <= ack_d;
    end
  end

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready & req;

  assert_read_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACC) |-> (!ce_n && !oe_n && we_n && !drv));
  assert_turn_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_TURN) |-> (ce_n && oe_n && !drv && !ready));
  assert_busy_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && req && state_q != ST_WR_HOLD && !(state_q == ST_RD_TURN && tmr_expired))
      |=> !ready);
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d, rdata_d;

  always_comb begin
    addr_d  = mem_addr;
    wdata_d = mem_dout;
    rdata_d = rdata;
    if (accept) begin
      addr_d  = host_addr;
      wdata_d = host_wdata;
    end
    if (capture) rdata_d = mem_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_dout <= '0;
      rdata    <= '0;
    end else begin
      mem_addr <= addr_d;
      mem_dout <= wdata_d;
      rdata    <= rdata_d;
    end
  end

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rdata));
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned SPEED_BIN_NS  = 55,
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int unsigned RD_CYC  = read_cycles(SPEED_BIN_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC  = write_cycles(SPEED_BIN_NS, CLK_PERIOD_NS);
  localparam int unsigned TA_CYC  = turn_cycles(SPEED_BIN_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC = max3(RD_CYC, WP_CYC, TA_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC < 3) ? 1 : $clog2(MAX_CYC);

  logic rst_sync_n, accept, capture;

  sram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_seq_fsm #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (req),
    .req_write (req_write),
    .ready     (ready),
    .accept    (accept),
    .capture   (capture),
    .ack       (ack),
    .ce_n      (sram_ce_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .drv       (sram_dq_oe)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (accept),
    .capture    (capture),
    .host_addr  (req_addr),
    .host_wdata (req_wdata),
    .mem_din    (sram_dq_in),
    .mem_addr   (sram_addr),
    .mem_dout   (sram_dq_out),
    .rdata      (rdata)
  );

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sram_dq_oe |-> sram_oe_n);
  assert_drive_after_release_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sram_dq_oe) |-> $past(sram_oe_n));
  assert_we_gating_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n && sram_dq_oe));
  assert_data_setup_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sram_we_n) |-> $past(sram_dq_oe));
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sram_we_n) |-> sram_dq_oe);
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));
  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));
  assert_idle_deselect_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |-> sram_ce_n);
  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack |=> !ack);
endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
  // cycle counts from the 55 ns bin at a 20 ns clock, ceiling division
  localparam int N_RD = (55 + 19) / 20;
  localparam int N_WP = (45 + 19) / 20;
  localparam int N_TA = (20 + 19) / 20;

  typedef struct {
    logic ce_n, we_n, oe_n, drv, rdy, ack, chk_rd;
    logic [14:0] addr;
    logic [7:0]  wd, rd;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  sram_dq_in = 8'hE7;
  logic ready, ack, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  rdata, sram_dq_out;
  logic [14:0] sram_addr;

  int n_total = 0, n_fail = 0, cyc = 0, rd_run = 0;
  bit last_rdy = 1'b0, wr_act = 1'b0;
  logic [7:0]  wbuf = '0, exp_rdata = '0;
  logic [14:0] waddr = '0;
  logic [7:0]  bmem [int];
  exp_t q[$];

  always #10 clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .ack(ack),
    .rdata(rdata), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  function automatic logic [7:0] rd_mem(input logic [14:0] a);
    if (bmem.exists(int'(a))) return bmem[int'(a)];
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic exp_t mk(input logic ce_n, we_n, oe_n, drv, rdy, ack,
                              input logic [14:0] a, input logic [7:0] wd,
                              input string tag);
    exp_t e;
    e.ce_n = ce_n; e.we_n = we_n; e.oe_n = oe_n; e.drv = drv; e.rdy = rdy;
    e.ack = ack; e.chk_rd = 1'b0; e.addr = a; e.wd = wd; e.rd = '0; e.tag = tag;
    return e;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      check(1'b0, "watchdog", "run hung", cyc, 20000);
      finish_run();
    end
  end

  task automatic step(input bit poke);
    exp_t e;
    @(negedge clk);
    if (q.size() != 0) e = q.pop_front();
    else e = mk(1, 1, 1, 0, 1, 0, '0, '0, "R2");
    check(sram_ce_n === e.ce_n, e.tag, "ce_n", sram_ce_n, e.ce_n);
    check(sram_we_n === e.we_n, e.tag, "we_n", sram_we_n, e.we_n);
    check(sram_oe_n === e.oe_n, e.tag, "oe_n", sram_oe_n, e.oe_n);
    check(sram_dq_oe === e.drv, e.tag, "dq_oe", sram_dq_oe, e.drv);
    check(ready === e.rdy, e.tag, "ready", ready, e.rdy);
    check(ack === e.ack, (e.ack ? e.tag : "R9"), "ack", ack, e.ack);
    if (!e.ce_n) check(sram_addr === e.addr, "R6", "addr", sram_addr, e.addr);
    if (e.drv)   check(sram_dq_out === e.wd, "R6", "dq_out", sram_dq_out, e.wd);
    if (e.chk_rd) exp_rdata = e.rd;
    check(rdata === exp_rdata, "R4", "rdata", rdata, exp_rdata);
    check(!(sram_dq_oe && !sram_oe_n), "R8", "contention", sram_dq_oe, 0);
    last_rdy = e.rdy;
    // behavioural memory: write commits when the low overlap of ce/we ends
    if (!sram_ce_n && !sram_we_n) begin
      wr_act = 1'b1; wbuf = sram_dq_out; waddr = sram_addr;
    end else if (wr_act) begin
      bmem[int'(waddr)] = wbuf; wr_act = 1'b0;
    end
    if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_run++;
    else rd_run = 0;
    sram_dq_in = (rd_run >= N_RD) ? rd_mem(sram_addr) : 8'hE7;
    if (poke && !e.rdy) begin
      req = 1'b1; req_write = 1'b1; req_addr = 15'h4444; req_wdata = 8'hFF;
    end else begin
      req = 1'b0;
    end
  endtask

  task automatic txn(input bit w, input logic [14:0] a, input logic [7:0] d,
                     input bit poke);
    exp_t e;
    req = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    if (w) begin
      q.push_back(mk(0, 1, 1, 1, 0, 0, a, d, "R5"));
      for (int i = 0; i < N_WP; i++) q.push_back(mk(0, 0, 1, 1, 0, 0, a, d, "R5"));
      q.push_back(mk(0, 1, 1, 1, 0, 0, a, d, "R5"));
      q.push_back(mk(1, 1, 1, 0, 1, 1, a, d, "R7"));
    end else begin
      for (int i = 0; i < N_RD; i++) q.push_back(mk(0, 1, 0, 0, 0, 0, a, '0, "R3"));
      for (int i = 0; i < N_TA; i++) begin
        e = mk(1, 1, 1, 0, 0, (i == 0), a, '0, (i == 0) ? "R4" : "R8");
        if (i == 0) begin e.chk_rd = 1'b1; e.rd = rd_mem(a); end
        q.push_back(e);
      end
    end
    do step(poke); while (!last_rdy);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(sram_ce_n && sram_we_n && sram_oe_n, "R1", "ctrl in reset",
            {sram_ce_n, sram_we_n, sram_oe_n}, 7);
      check(!sram_dq_oe && ready && !ack && rdata == 8'h00, "R1", "host in reset",
            {sram_dq_oe, ready, ack}, 3'b010);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0);

    txn(1, 15'h0000, 8'h3C, 0);
    txn(1, 15'h7FFF, 8'hC3, 0);
    txn(1, 15'h1234, 8'h5A, 1);       // R2: strobes during busy dropped
    txn(0, 15'h7FFF, 8'h00, 0);
    txn(1, 15'h2222, 8'h99, 0);       // R8: read then write turnaround
    txn(0, 15'h0000, 8'h00, 1);
    txn(0, 15'h1234, 8'h00, 0);       // read then read
    txn(0, 15'h0ABC, 8'h00, 0);       // unwritten location
    txn(0, 15'h2222, 8'h00, 0);
    txn(0, 15'h4444, 8'h00, 0);       // R2: poked address must be untouched
    for (int k = 0; k < 8; k++) begin
      txn(1, 15'(k * 4099 + 7), 8'(k * 37 + 1), k[0]);
      if (k[1]) step(0);
    end
    for (int k = 0; k < 8; k++) txn(0, 15'(k * 4099 + 7), 8'h00, 0);
    txn(0, 15'h4444, 8'h00, 0);
    for (int i = 0; i < 3; i++) step(0);
    finish_run();
  end
endmodule